// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside the command bus of a four-bank mobile SDRAM and mirrors the state of the device. It samples chip select, the three active-low command strobes, the bank address and the 13-bit address on each rising clock edge. From these it keeps an open/closed flag and the latched row for every bank. It follows auto-precharge requests and precharge-all requests, and it reports a protocol error when a command does not fit the current bank state.

When clock enable is sampled low, the tracker chooses one of three low-power states: precharge power-down, active power-down or suspend. The choice depends on whether any row is open and whether a burst is still running. A controller or monitor reads the outputs to check its own bookkeeping.

The block has no data stream, so every pin is a plain control or status signal. It applies no back-pressure. A `burst_len` input gives the burst length in cycles, and the auto-precharge timing uses it. Commands use these strobe patterns `{ras_n,cas_n,we_n}`, taken with `cs_n` low:

- 011 opens a row.
- 101 is a read.
- 100 is a write.
- 010 is a precharge.

Every other pattern is a no-op.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Reset (rst_n low) clears every bank_open bit and proto_err, and sets pwr_state to 0 (normal).
- R2: A command sampled with cs_n high changes no bank state, even when the strobes form a precharge-all pattern.
- R3: A row-open command (strobes 011) to a closed bank sets bank_open[ba] on the next edge and stores addr[12:0] in bank_row slice ba (bits ba*13 +: 13).
- R4: A precharge (strobes 010) with addr[10] low closes only bank ba.
- R5: A precharge with addr[10] high closes all four banks, whatever the value of ba.
- R6: A read or write to an open bank with addr[10] high closes that bank on the edge burst_len edges after the one that accepted it. A burst_len of 0 acts as 1.
- R7: A read or write with addr[10] low leaves the bank open indefinitely.
- R8: A read or write to a closed bank, or a row-open command to an already open bank, sets proto_err. proto_err then stays high until reset. A row-open command to an open bank does not change its stored row.
- R9: On the first edge with cke low and no bank open, pwr_state becomes 1 (precharge power-down).
- R10: On the first edge with cke low, with a bank open and no burst running, pwr_state becomes 2 (active power-down).
- R11: On the first edge with cke low while a burst is running, pwr_state becomes 3 (suspend). Burst counting freezes while cke stays low.
- R12: While cke is low, all commands are ignored and bank state is held. The first edge with cke high returns pwr_state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable from the command bus |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row address, column address, and the precharge-control bit addr[10] |
| burst_len | input | 4 | Burst length in cycles, used for auto-precharge timing |
| bank_open | output | 4 | One open flag per bank |
| bank_row | output | 52 | Open row of each bank, 13 bits per bank |
| pwr_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 suspend |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench opens rows in different banks with distinct row values. It then closes them with single-bank and all-bank precharges, which shows that bank selection and the all-bank override act separately. Reads and writes are issued with and without the auto-precharge bit, and at two burst lengths including zero. Each case is sampled on the edge just before and the edge just after the expected close, which separates an off-by-one countdown from a correct one.

Clock enable is dropped in three settings: all banks idle, a row open, and mid-burst. Each setting must map to its own power code. Commands issued while clock enable is low must leave the banks untouched. Masked commands and misordered commands check the ignore path and the sticky error.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'd0,
    PWR_PPD    = 2'd1,
    PWR_APD    = 2'd2,
    PWR_SUSP   = 2'd3
  } pwr_e;
endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot #(
  parameter int ROW_W = 13,
  parameter int BL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             act_hit,
  input  logic             acc_hit,
  input  logic             acc_ap,
  input  logic             pre_hit,
  input  logic [ROW_W-1:0] row_in,
  input  logic [BL_W-1:0]  bl_eff,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);
  logic [BL_W-1:0] ap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
      ap_cnt  <= '0;
    end else if (en) begin
      if (pre_hit) begin
        is_open <= 1'b0;
        ap_cnt  <= '0;
      end else if (act_hit) begin
        is_open <= 1'b1;
        row_q   <= row_in;
        ap_cnt  <= '0;
      end else if (acc_hit) begin
        ap_cnt  <= acc_ap ? bl_eff : '0;
      end else if (ap_cnt == BL_W'(1)) begin
        is_open <= 1'b0;
        ap_cnt  <= '0;
      end else if (ap_cnt != '0) begin
        ap_cnt  <= ap_cnt - BL_W'(1);
      end
    end
  end
endmodule

// File: rtl/sbt_power_class.sv
module sbt_power_class
  import sbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic any_open,
  input  logic busy,
  output pwr_e pwr
);
  always_ff @(posedge clk) begin
    if (!rst_n)                pwr <= PWR_NORMAL;
    else if (cke)              pwr <= PWR_NORMAL;
    else if (pwr == PWR_NORMAL) begin
      if (!any_open)           pwr <= PWR_PPD;
      else if (busy)           pwr <= PWR_SUSP;
      else                     pwr <= PWR_APD;
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BL_W      = 4,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic [BL_W-1:0]            burst_len,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic [1:0]                 pwr_state,
  output logic                       proto_err
);
  cmd_e            cmd;
  logic            c_act, c_rdwr, c_pre, sel_open;
  logic [BL_W-1:0] bl_eff, acc_cnt;
  logic            busy;
  pwr_e            pwr;

  sbt_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign c_act    = cke && (cmd == CMD_ACT);
  assign c_rdwr   = cke && (cmd == CMD_RD || cmd == CMD_WR);
  assign c_pre    = cke && (cmd == CMD_PRE);
  assign sel_open = bank_open[ba];
  assign bl_eff   = (burst_len == '0) ? BL_W'(1) : burst_len;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(g));
    sbt_bank_slot #(.ROW_W(ROW_W), .BL_W(BL_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cke),
      .act_hit (sel && c_act && !bank_open[g]),
      .acc_hit (sel && c_rdwr && bank_open[g]),
      .acc_ap  (addr[AP_BIT]),
      .pre_hit (c_pre && (sel || addr[AP_BIT])),
      .row_in  (addr),
      .bl_eff  (bl_eff),
      .is_open (bank_open[g]),
      .row_q   (bank_row[g*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt   <= '0;
      proto_err <= 1'b0;
    end else if (cke) begin
      if (c_rdwr && sel_open)   acc_cnt <= bl_eff;
      else if (acc_cnt != '0)   acc_cnt <= acc_cnt - BL_W'(1);
      if ((c_rdwr && !sel_open) || (c_act && sel_open)) proto_err <= 1'b1;
    end
  end

  assign busy = (acc_cnt != '0) && (|bank_open);

  sbt_power_class u_pwr (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .any_open(|bank_open), .busy(busy), .pwr(pwr)
  );

  assign pwr_state = pwr;
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cke,
  input logic                       cs_n,
  input logic                       ras_n,
  input logic                       cas_n,
  input logic                       we_n,
  input logic [BA_W-1:0]            ba,
  input logic [ROW_W-1:0]           addr,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row,
  input logic [1:0]                 pwr_state,
  input logic                       proto_err
);
  logic is_act, is_pre;
  assign is_act = cke && !cs_n && !ras_n && cas_n && we_n;
  assign is_pre = cke && !cs_n && !ras_n && cas_n && !we_n;

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> bank_open[$past(ba)]);

  assert_pre_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && !addr[AP_BIT]) |=> !bank_open[$past(ba)]);

  assert_pre_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && addr[AP_BIT]) |=> (bank_open == '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_ppd_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && pwr_state == 2'd0 && bank_open == '0) |=> (pwr_state == 2'd1));

  assert_cke_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(bank_open) && $stable(bank_row)));

  assert_cke_normal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> (pwr_state == 2'd0));
endmodule

bind sdram_bank_tracker sbt_checker #(
  .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ROW_W(ROW_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
  .bank_row(bank_row), .pwr_state(pwr_state), .proto_err(proto_err)
);

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  burst_len = 4'd4;
  logic [3:0]  bank_open;
  logic [51:0] bank_row;
  logic [1:0]  pwr_state;
  logic        proto_err;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct packed {
    logic [3:0]  open;
    logic [1:0]  pwr;
    logic        err;
    logic        row_chk;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [31:0] due;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_bank_tracker u_sdram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .burst_len(burst_len),
    .bank_open(bank_open), .bank_row(bank_row), .pwr_state(pwr_state),
    .proto_err(proto_err)
  );

  // monitor: compares queued expectations shortly after each falling edge
  always begin
    @(negedge clk);
    #1;
    while (exp_q.size() > 0 && exp_q[0].due <= 32'(cyc)) begin
      exp_t  e;
      string t;
      logic [12:0] r;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      r = bank_row[e.bank*13 +: 13];
      checks++;
      if (bank_open !== e.open || pwr_state !== e.pwr || proto_err !== e.err ||
          (e.row_chk && r !== e.row)) begin
        fails++;
        $display("FAIL %s: open=%b pwr=%0d err=%b row=%h | expected open=%b pwr=%0d err=%b row=%h",
                 t, bank_open, pwr_state, proto_err, r, e.open, e.pwr, e.err, e.row);
      end
    end
  end

  task automatic expect_st(string t, logic [3:0] o, logic [1:0] p, logic e,
                           logic rc = 0, logic [1:0] b = 0, logic [12:0] r = 0);
    exp_t x;
    x.open = o; x.pwr = p; x.err = e; x.row_chk = rc; x.bank = b; x.row = r;
    x.due = 32'(cyc);
    exp_q.push_back(x);
    tag_q.push_back(t);
  endtask

  task automatic op(logic k, logic c, logic [2:0] s, logic [1:0] b, logic [12:0] a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = s; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic act(logic [1:0] b, logic [12:0] r);     op(1, 0, 3'b011, b, r); endtask
  task automatic rd(logic [1:0] b, logic ap);            op(1, 0, 3'b101, b, {2'b0, ap, 10'h01}); endtask
  task automatic wr(logic [1:0] b, logic ap);            op(1, 0, 3'b100, b, {2'b0, ap, 10'h02}); endtask
  task automatic pre(logic [1:0] b, logic all);          op(1, 0, 3'b010, b, {2'b0, all, 10'h0}); endtask
  task automatic nop(int n = 1);
    for (int i = 0; i < n; i++) op(1, 0, 3'b111, 2'd0, 13'h0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    op(1, 1, 3'b111, 0, 0);
    op(1, 1, 3'b111, 0, 0);
    rst_n = 1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    expect_st("R1 reset state", 4'b0000, 0, 0);

    act(0, 13'h1ABC);
    expect_st("R3 open bank0 row", 4'b0001, 0, 0, 1, 0, 13'h1ABC);
    op(1, 1, 3'b010, 2'd0, 13'h0400);
    expect_st("R2 deselected precharge-all ignored", 4'b0001, 0, 0);
    act(2, 13'h0123);
    expect_st("R3 open bank2 row", 4'b0101, 0, 0, 1, 2, 13'h0123);
    pre(0, 0);
    expect_st("R4 single precharge bank0", 4'b0100, 0, 0, 1, 2, 13'h0123);
    act(1, 13'h1FFF);
    act(3, 13'h0004);
    expect_st("R3 open banks 1 and 3", 4'b1110, 0, 0, 1, 3, 13'h0004);
    pre(3, 1);
    expect_st("R5 precharge all", 4'b0000, 0, 0);

    act(1, 13'h0005);
    rd(1, 1);
    expect_st("R6 read auto-precharge accepted", 4'b0010, 0, 0);
    nop(3);
    expect_st("R6 open one edge before close", 4'b0010, 0, 0);
    nop(1);
    expect_st("R6 closed at burst_len edges", 4'b0000, 0, 0);

    act(1, 13'h0006);
    wr(1, 0);
    nop(6);
    expect_st("R7 write without auto-precharge stays open", 4'b0010, 0, 0);

    op(0, 0, 3'b111, 0, 0);
    expect_st("R10 cke low with open row", 4'b0010, 2, 0);
    op(0, 0, 3'b010, 1, 13'h0400);
    expect_st("R12 precharge ignored while cke low", 4'b0010, 2, 0);
    nop(1);
    expect_st("R12 cke high returns normal", 4'b0010, 0, 0);

    pre(0, 1);
    op(0, 1, 3'b111, 0, 0);
    expect_st("R9 cke low all idle", 4'b0000, 1, 0);
    nop(1);

    act(0, 13'h0AAA);
    rd(0, 1);
    op(0, 0, 3'b111, 0, 0);
    expect_st("R11 cke low during burst", 4'b0001, 3, 0);
    op(0, 0, 3'b111, 0, 0);
    op(0, 0, 3'b111, 0, 0);
    expect_st("R11 suspend holds bank", 4'b0001, 3, 0);
    nop(3);
    expect_st("R11 burst frozen while suspended", 4'b0001, 0, 0);
    nop(1);
    expect_st("R11 burst resumes then closes", 4'b0000, 0, 0);

    burst_len = 4'd0;
    act(0, 13'h0011);
    rd(0, 1);
    expect_st("R6 zero burst length accepted", 4'b0001, 0, 0);
    nop(1);
    expect_st("R6 zero burst length acts as one", 4'b0000, 0, 0);

    act(3, 13'h0777);
    act(3, 13'h0888);
    expect_st("R8 open to open bank flags error, row kept", 4'b1000, 0, 1, 1, 3, 13'h0777);
    nop(2);
    expect_st("R8 error sticky", 4'b1000, 0, 1);
    do_reset();
    expect_st("R1 reset clears error and banks", 4'b0000, 0, 0);
    wr(2, 0);
    expect_st("R8 write to closed bank flags error", 4'b0000, 0, 1);

    nop(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule